// File: doc/BRIEF.md
# Cache Flush Sequencer with TLB Reset

This block carries out a full flush of a set-associative data cache. When the processor issues a flush command, a slot counter walks every position of the cache, one slot per cycle. Each position is presented to the tag array as a set index and a way index. A slot that holds a valid line is invalidated in the tag array. In the same cycle its line number is loaded into a single cleanup request register, which the coherence transport drains.

While that request is still pending the walk holds still, so at most one cleanup is outstanding at any time. Every slot the walk visits also gets a clear strobe for its per-slot translation-link flags. These are the flag that marks a line referenced by a TLB and the flag that marks a line holding a page-table directory. When the final slot has been handled, the block resets the instruction TLB and the data TLB, global entries included. In the same cycle it returns a one-cycle completion response to the processor and goes back to idle.

The slot number is `way*SETS + set`. The set is taken from the low bits of the counter and the way from the high bits, so within each way the walk covers the sets in ascending order before moving to the next way. The cache geometry is set by parameters. Both `SETS` and `WAYS` are powers of two, and `WAYS` is at least 2.

Top module: `cflush_seq`

## Requirements
- R1: While reset is asserted and after its release, `cln_req`, `tag_inval`, `link_clr`, `flush_done`, `itlb_rst` and `dtlb_rst` are all low, and the block is idle.
- R2: A high `flush_req` sampled while idle starts a walk at slot 0. Slots are then visited in ascending order 0 to `SETS*WAYS-1`. The slot number is `way*SETS + set`, `tag_set` carries its low `log2(SETS)` bits and `tag_way` its high bits.
- R3: Every visited slot produces exactly one cycle with `link_clr` high and `link_idx` equal to that slot number.
- R4: When the visited slot has `tag_valid_in` high, `tag_inval` is high in that cycle. On the next cycle `cln_req` is high and `cln_line` holds the `tag_line_in` value of that slot.
- R5: A slot with `tag_valid_in` low takes one cycle, with `tag_inval` low and no cleanup posted.
- R6: While `cln_req` is high, the walk does not advance: `link_clr`, `tag_inval` and `flush_done` stay low.
- R7: `cln_req` stays high until `cln_taken` is sampled high, and it is low on the cycle after that.
- R8: In the cycle that handles the last slot, `flush_done`, `itlb_rst` and `dtlb_rst` pulse high together for one cycle, and the block then returns to idle.
- R9: A `flush_req` sampled while a walk is in progress is ignored: that walk produces exactly one completion pulse, and no second walk follows it.
- R10: From the cycle after acceptance, completion comes after `SETS*WAYS` cycles plus the number of cycles spent stalled on a pending cleanup before the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_req | input | 1 | Flush command from the processor |
| flush_done | output | 1 | One-cycle completion response |
| tag_set | output | log2(SETS) | Set index of the visited slot |
| tag_way | output | log2(WAYS) | Way index of the visited slot |
| tag_valid_in | input | 1 | Valid bit of the addressed slot (combinational read) |
| tag_line_in | input | LINE_W | Line number stored in the addressed slot |
| tag_inval | output | 1 | Invalidate strobe for the addressed slot |
| cln_req | output | 1 | Pending cleanup request flag |
| cln_line | output | LINE_W | Line number of the pending cleanup |
| cln_taken | input | 1 | Transport has consumed the cleanup request |
| link_clr | output | 1 | Clear strobe for the slot's TLB-link and directory flags |
| link_idx | output | log2(SETS*WAYS) | Slot number for the flag clear |
| itlb_rst | output | 1 | Full instruction TLB reset strobe |
| dtlb_rst | output | 1 | Full data TLB reset strobe |

## Verification
The assertions assume that `tag_valid_in` and `tag_line_in` describe the slot currently addressed, in the same cycle, and that `cln_taken` is raised only while `cln_req` is high. The stimulus respects both assumptions. The bench's tag model looks up the valid bit and line number combinationally from `tag_set` and `tag_way`, and clears the valid bit on `tag_inval`. Its transport model raises `cln_taken` only after it has seen `cln_req`, after a delay that each vector sets, so the walk is stalled for a known number of cycles per cleanup.

// File: rtl/cflush_pkg.sv
package cflush_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_t;
endpackage

// File: rtl/cflush_walk_ctr.sv
module cflush_walk_ctr #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned CNT_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = clr | step;
    cnt_nxt = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  assign at_last = (cnt == LAST);
endmodule

// File: rtl/cflush_cleanup_reg.sv
module cflush_cleanup_reg #(
  parameter int unsigned LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post,
  input  logic [LINE_W-1:0] line_in,
  input  logic              taken,
  output logic              req,
  output logic [LINE_W-1:0] line
);
  logic req_nxt;

  always_comb begin
    req_nxt = req;
    if (post)       req_nxt = 1'b1;
    else if (taken) req_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line <= '0;
    else if (post) line <= line_in;
  end
endmodule

// File: rtl/cflush_seq.sv
module cflush_seq
  import cflush_pkg::*;
#(
  parameter int unsigned SETS   = 4,
  parameter int unsigned WAYS   = 2,
  parameter int unsigned LINE_W = 26,
  localparam int unsigned SLOTS = SETS * WAYS,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_req,
  output logic              flush_done,
  output logic [SET_W-1:0]  tag_set,
  output logic [WAY_W-1:0]  tag_way,
  input  logic              tag_valid_in,
  input  logic [LINE_W-1:0] tag_line_in,
  output logic              tag_inval,
  output logic              cln_req,
  output logic [LINE_W-1:0] cln_line,
  input  logic              cln_taken,
  output logic              link_clr,
  output logic [IDX_W-1:0]  link_idx,
  output logic              itlb_rst,
  output logic              dtlb_rst
);
  walk_state_t      state_q, state_d;
  logic [IDX_W-1:0] slot;
  logic             at_last;
  logic             start;
  logic             go;
  logic             finish;

  always_comb begin
    start  = (state_q == ST_IDLE) && flush_req;
    go     = (state_q == ST_WALK) && !cln_req;
    finish = go && at_last;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start)  state_d = ST_WALK;
      ST_WALK: if (finish) state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  cflush_walk_ctr #(.SLOTS(SLOTS)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .step    (go),
    .cnt     (slot),
    .at_last (at_last)
  );

  cflush_cleanup_reg #(.LINE_W(LINE_W)) u_cln (
    .clk     (clk),
    .rst_n   (rst_n),
    .post    (tag_inval),
    .line_in (tag_line_in),
    .taken   (cln_taken),
    .req     (cln_req),
    .line    (cln_line)
  );

  assign tag_set    = slot[SET_W-1:0];
  assign tag_way    = slot[IDX_W-1:SET_W];
  assign tag_inval  = go && tag_valid_in;
  assign link_clr   = go;
  assign link_idx   = slot;
  assign flush_done = finish;
  assign itlb_rst   = finish;
  assign dtlb_rst   = finish;
endmodule

// File: rtl/cflush_seq_chk.sv
module cflush_seq_chk #(
  parameter int unsigned SETS   = 4,
  parameter int unsigned WAYS   = 2,
  parameter int unsigned LINE_W = 26,
  localparam int unsigned IDX_W = $clog2(SETS * WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_done,
  input logic              tag_valid_in,
  input logic [LINE_W-1:0] tag_line_in,
  input logic              tag_inval,
  input logic              cln_req,
  input logic [LINE_W-1:0] cln_line,
  input logic              cln_taken,
  input logic              link_clr,
  input logic [IDX_W-1:0]  link_idx,
  input logic              itlb_rst,
  input logic              dtlb_rst
);
  assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_clr && !flush_done) |=> (!link_clr || link_idx == IDX_W'($past(link_idx) + 1'b1)));

  assert_inval_visit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tag_inval |-> (tag_valid_in && link_clr));

  assert_post_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tag_inval |=> (cln_req && cln_line == $past(tag_line_in)));

  assert_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_clr && !tag_valid_in) |=> !cln_req);

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cln_req |-> (!link_clr && !tag_inval && !flush_done));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cln_req && !cln_taken) |=> (cln_req && $stable(cln_line)));

  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cln_req && cln_taken) |=> !cln_req);

  assert_tlb_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (itlb_rst || dtlb_rst || flush_done) |-> (itlb_rst && dtlb_rst && flush_done));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);
endmodule

bind cflush_seq cflush_seq_chk #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_done   (flush_done),
  .tag_valid_in (tag_valid_in),
  .tag_line_in  (tag_line_in),
  .tag_inval    (tag_inval),
  .cln_req      (cln_req),
  .cln_line     (cln_line),
  .cln_taken    (cln_taken),
  .link_clr     (link_clr),
  .link_idx     (link_idx),
  .itlb_rst     (itlb_rst),
  .dtlb_rst     (dtlb_rst)
);

// File: tb/cflush_seq_tb.sv
`timescale 1ns/1ps
module cflush_seq_tb;
  localparam int SETS   = 4;
  localparam int WAYS   = 2;
  localparam int LINE_W = 26;
  localparam int SLOTS  = SETS * WAYS;

  // Vector fields: valid mask, cleanup take delay, expected done cycle.
  localparam logic [23:0] VEC [5] = '{
    {8'h00, 8'd1, 8'd8},
    {8'hFF, 8'd1, 8'd15},
    {8'h81, 8'd3, 8'd11},
    {8'h5A, 8'd2, 8'd16},
    {8'h80, 8'd4, 8'd8}
  };

  logic clk, rst_n, flush_req, flush_done, tag_valid_in, tag_inval;
  logic cln_req, cln_taken, link_clr, itlb_rst, dtlb_rst;
  logic [1:0] tag_set;
  logic [0:0] tag_way;
  logic [2:0] link_idx;
  logic [LINE_W-1:0] tag_line_in, cln_line;

  logic vld [SLOTS];
  int   dly, wcnt;
  int   checks, errors;

  cflush_seq #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .flush_done(flush_done),
    .tag_set(tag_set), .tag_way(tag_way), .tag_valid_in(tag_valid_in),
    .tag_line_in(tag_line_in), .tag_inval(tag_inval), .cln_req(cln_req),
    .cln_line(cln_line), .cln_taken(cln_taken), .link_clr(link_clr),
    .link_idx(link_idx), .itlb_rst(itlb_rst), .dtlb_rst(dtlb_rst)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Tag array model: combinational read, invalidate on strobe.
  assign tag_valid_in = vld[{tag_way, tag_set}];
  assign tag_line_in  = LINE_W'(32'h100 + {tag_way, tag_set});
  always @(posedge clk) if (tag_inval) vld[{tag_way, tag_set}] <= 1'b0;

  // Transport model: take the cleanup after dly samples of cln_req.
  always @(negedge clk) begin
    if (cln_req) begin
      cln_taken = (wcnt >= dly - 1);
      wcnt = cln_taken ? 0 : wcnt + 1;
    end else begin
      cln_taken = 1'b0;
      wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_flush(input logic [7:0] mask, input int d, input int exp_cyc);
    int cyc, nidx, ninv, bad_ord, bad_line, ntlb, bad_tlb, pend, left;
    bit prev;
    for (int i = 0; i < SLOTS; i++) vld[i] = mask[i];
    dly = d;
    cyc = 0; nidx = 0; ninv = 0; bad_ord = 0; bad_line = 0; ntlb = 0; bad_tlb = 0;
    pend = 0; prev = 0;
    @(negedge clk) flush_req = 1'b1;
    while (cyc < 200) begin
      @(negedge clk);
      flush_req = 1'b0;
      cyc++;
      if (cln_req && !prev && cln_line != LINE_W'(pend)) bad_line++;
      prev = cln_req;
      if (link_clr) begin
        if (int'(link_idx) != nidx || {tag_way, tag_set} != link_idx) bad_ord++;
        nidx++;
      end
      if (tag_inval) begin ninv++; pend = 32'h100 + int'(link_idx); end
      if (itlb_rst || dtlb_rst) begin
        ntlb++;
        if (!(itlb_rst && dtlb_rst && flush_done)) bad_tlb++;
      end
      if (flush_done) break;
    end
    chk(cyc == exp_cyc, "R10 done cycle", cyc, exp_cyc);
    chk(nidx == SLOTS && bad_ord == 0, "R2/R3 slot order R2 R3", bad_ord, 0);
    chk(ninv == $countones(mask), "R4/R5 cleanup count R4 R5", ninv, $countones(mask));
    chk(ntlb == 1 && bad_tlb == 0, "R8 tlb pulses", ntlb, 1);
    left = 0;
    repeat (20) begin
      @(negedge clk);
      if (cln_req && !prev && cln_line != LINE_W'(pend)) bad_line++;
      prev = cln_req;
    end
    chk(bad_line == 0, "R4 cleanup line", bad_line, 0);
    chk(!cln_req, "R7 cleanup drained", cln_req, 0);
    for (int i = 0; i < SLOTS; i++) left += vld[i];
    chk(left == 0, "R4 lines invalidated", left, 0);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ndone, cyc, first;
    checks = 0; errors = 0; dly = 1; wcnt = 0; cln_taken = 1'b0;
    flush_req = 1'b0;
    for (int i = 0; i < SLOTS; i++) vld[i] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cln_req && !tag_inval && !link_clr && !flush_done && !itlb_rst && !dtlb_rst,
        "R1 reset outputs", cln_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!link_clr && !flush_done, "R1 idle after reset", link_clr, 0);

    for (int v = 0; v < 5; v++)
      run_flush(VEC[v][23:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));

    // R9: a second command during the walk is ignored.
    dly = 1;
    @(negedge clk) flush_req = 1'b1;
    ndone = 0; first = 0; cyc = 0;
    repeat (30) begin
      @(negedge clk);
      cyc++;
      flush_req = (cyc == 3);
      if (flush_done) begin ndone++; if (first == 0) first = cyc; end
    end
    chk(ndone == 1, "R9 single completion", ndone, 1);
    chk(first == SLOTS, "R9 completion timing", first, SLOTS);

    // R1: reset during a walk returns to idle with no completion.
    @(negedge clk) flush_req = 1'b1;
    @(negedge clk) flush_req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    ndone = 0;
    repeat (20) begin
      @(negedge clk);
      if (flush_done || link_clr) ndone++;
    end
    chk(ndone == 0, "R1 reset aborts walk", ndone, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule